// File: doc/BRIEF.md
# Early-Terminating Multiply-Accumulate Unit

This block computes the low 32 bits of `acc_in + mcand * mplier` over several clock cycles. It handles one byte of the multiplier per cycle. It stops as soon as the multiplier bits that remain are nothing more than the sign extension of the bits already handled. The number of cycles therefore depends on the data: one to four.

An operation starts with a single-cycle `start` pulse while the unit is idle. `busy` then stays high for one cycle per multiplier byte actually processed. `done` pulses in the cycle after `busy` falls, and `result` is valid from that cycle on.

The negative and zero flags are refreshed from the result only if the operation was issued with `set_flags` high or with `compressed` high. Otherwise the flags keep their previous values.

Top module: `mac_early_term`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `flag_n` and `flag_z` are all 0.
- R2: On completion, `result` equals (`acc_in` + `mcand` * `mplier`) modulo 2^32, using the operands captured with the accepted start.
- R3: `busy` stays high for exactly K consecutive cycles after the accepted start. K starts at 1 and gains 1 for each of these ranges that is neither all zeros nor all ones: `mplier[31:8]`, `mplier[31:16]`, `mplier[31:24]`.
- R4: `done` is high for exactly one cycle, namely the cycle right after `busy` falls. `busy` is low in that cycle.
- R5: A `start` that arrives while `busy` is high is ignored: it affects neither the operands, the result nor the latency.
- R6: When the operation was issued with `set_flags` = 1 or `compressed` = 1, the flags are set at completion: `flag_n` = `result[31]`, and `flag_z` = 1 exactly when `result` is 0.
- R7: When both `set_flags` and `compressed` were 0 at issue, `flag_n` and `flag_z` keep their earlier values.
- R8: While the unit is idle and no start is accepted, `result`, `flag_n` and `flag_z` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| acc_in | input | 32 | Accumulator addend |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier; its upper bytes set the latency |
| set_flags | input | 1 | Request a flag update |
| compressed | input | 1 | Compressed-mode bit; also forces a flag update |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Accumulated product, low 32 bits |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest situation to reach from the ports is a negative multiplier that terminates early. In that case the last processed byte must be weighted as a signed value, even though its own top bit may disagree with the sign above it, as in 0xFFFFFF12. Uniform random multipliers almost never have all-ones upper bytes. The stimulus therefore draws a latency class first and then builds a multiplier whose upper bytes are forced to all zeros or all ones, with the sign chosen at random. Directed cases add the boundary patterns 0xFFFFFF12, 0xFFFF8000 and 0x80000000.

// File: rtl/mac_early_term.sv
module mac_early_term #(
  parameter int W     = 32,
  parameter int SLICE = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic         set_flags,
  input  logic         compressed,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z
);
  localparam int NSTEP = W / SLICE;
  localparam int CW    = $clog2(NSTEP + 1);

  logic [W-1:0]  acc_r, mc_r, mp_r;
  logic [CW-1:0] left_r, steps;
  logic          busy_r, done_r, upd_r, n_r, z_r;

  always_comb begin
    steps = CW'(1);
    for (int j = 1; j < NSTEP; j++) begin
      logic [W-1:0] hi;
      hi = $signed(mp_in_sx(mplier)) >>> (j * SLICE);
      if (hi != '0 && hi != '1) steps = steps + CW'(1);
    end
  end

  function automatic logic [W-1:0] mp_in_sx(input logic [W-1:0] v);
    return v;
  endfunction

  wire           last = (left_r == CW'(1));
  wire           ext  = last & mp_r[W-1];
  wire [W-1:0]   term = mc_r * {{(W-SLICE){ext}}, mp_r[SLICE-1:0]};
  wire [W-1:0]   sum  = acc_r + term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_r  <= '0;
      mc_r   <= '0;
      mp_r   <= '0;
      left_r <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
      upd_r  <= 1'b0;
      n_r    <= 1'b0;
      z_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !busy_r) begin
        acc_r  <= acc_in;
        mc_r   <= mcand;
        mp_r   <= mplier;
        left_r <= steps;
        busy_r <= 1'b1;
        upd_r  <= set_flags | compressed;
      end else if (busy_r) begin
        acc_r  <= sum;
        mc_r   <= mc_r << SLICE;
        mp_r   <= $signed(mp_r) >>> SLICE;
        left_r <= left_r - CW'(1);
        if (last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
          if (upd_r) begin
            n_r <= sum[W-1];
            z_r <= (sum == '0);
          end
        end
      end
    end
  end

  assign busy   = busy_r;
  assign done   = done_r;
  assign result = acc_r;
  assign flag_n = n_r;
  assign flag_z = z_r;
endmodule

// File: rtl/mac_early_term_chk.sv
module mac_early_term_chk #(
  parameter int W     = 32,
  parameter int SLICE = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         flag_n,
  input logic         flag_z
);
  localparam int NSTEP = W / SLICE;
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R4
  AST_MAX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < NSTEP)); // R3
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(flag_n) && $stable(flag_z))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R8
endmodule

bind mac_early_term mac_early_term_chk #(.W(W), .SLICE(SLICE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/tb_mac_early_term.sv
module tb_mac_early_term;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] acc_in = '0, mcand = '0, mplier = '0;
  logic        set_flags = 1'b0, compressed = 1'b0;
  logic        busy, done, flag_n, flag_z;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  always #2.5 clk = ~clk;

  mac_early_term dut (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in), .mcand(mcand),
    .mplier(mplier), .set_flags(set_flags), .compressed(compressed),
    .busy(busy), .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic int exp_cycles(input logic [31:0] m);
    int k = 1;
    if (m[31:8]  != 24'h0 && m[31:8]  != 24'hFFFFFF) k++;
    if (m[31:16] != 16'h0 && m[31:16] != 16'hFFFF)   k++;
    if (m[31:24] != 8'h0  && m[31:24] != 8'hFF)      k++;
    return k;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] c, input logic [31:0] m,
                        input bit sf, input bit cm, input bit inject);
    logic [31:0] expr;
    int cnt;
    expr = a + c * m;
    @(negedge clk);
    acc_in = a; mcand = c; mplier = m; set_flags = sf; compressed = cm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 20) begin
      cnt++;
      if (inject && cnt == 1) begin
        acc_in = ~a; mcand = c + 32'd3; mplier = 32'h7F00_1234; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (sf || cm) begin exp_n = expr[31]; exp_z = (expr == 0); end
    chk(cnt == exp_cycles(m), inject ? "R5 latency with ignored start" : "R3 busy cycles",
        32'(cnt), 32'(exp_cycles(m)));
    chk(done == 1'b1, "R4 done after busy", 32'(done), 32'd1);
    chk(result == expr, inject ? "R5 result with ignored start" : "R2 result", result, expr);
    chk(flag_n == exp_n && flag_z == exp_z, (sf || cm) ? "R6 flags updated" : "R7 flags held",
        {30'd0, flag_n, flag_z}, {30'd0, exp_n, exp_z});
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R4 done one cycle", {30'd0, done, busy}, 32'd0);
    chk(result == expr, "R8 result holds while idle", result, expr);
  endtask

  function automatic logic [31:0] shaped(input int cls, input logic [31:0] v);
    logic s = v[31];
    case (cls)
      0: return {{24{s}}, v[7:0]};
      1: return {{16{s}}, v[15:0]};
      2: return {{8{s}},  v[23:0]};
      default: return v;
    endcase
  endfunction

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250607));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && result == 0 && flag_n == 0 && flag_z == 0,
        "R1 reset state", {27'd0, busy, done, flag_n, flag_z, |result}, 32'd0);
    rst_n = 1'b1;
    run_op(32'd5,        32'd3,        32'h0000_0012, 1, 0, 0);
    run_op(32'd0,        32'd7,        32'hFFFF_FF80, 1, 0, 0);
    run_op(32'h100,      32'h1111,     32'h0000_1234, 0, 1, 0);
    run_op(32'hDEAD_BEEF,32'h0BAD_F00D,32'h1234_5678, 0, 0, 0);
    run_op(32'd1,        32'h8000_0001,32'hFFFF_FF12, 1, 0, 0);
    run_op(32'd9,        32'd4,        32'hFFFF_8000, 0, 0, 0);
    run_op(32'd0,        32'h1234,     32'h0000_0000, 1, 1, 0);
    run_op(32'h4000_0000,32'd3,        32'h8000_0000, 1, 0, 0);
    run_op(32'd12,       32'd21,       32'h0012_3456, 0, 1, 1);
    run_op(32'hFFFF_FFFF,32'd1,        32'h0000_0001, 1, 0, 0);
    for (int i = 0; i < 60; i++) begin
      int cls = int'($urandom % 4);
      run_op($urandom, $urandom, shaped(cls, $urandom), $urandom % 2 == 0,
             $urandom % 4 == 0, $urandom % 5 == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule